// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

A single timer channel with a word-indexed register port. A down-counter is stepped by a prescaled timer tick. It can run in one of three modes. In free-running mode it wraps to all-ones. In periodic mode it reloads a programmed value. In one-shot mode it stops at zero. The counter is either 16 or 32 bits wide.

Software can program the reload value in two ways. An immediate load also restarts the count. A background load changes only the value used at the next wrap. Software sees a raw interrupt flag and a masked view of it, and clears the flag by writing to a dedicated register. The level interrupt output is the raw flag gated by the interrupt-enable bit.

Top module: `interval_timer`

## Requirements
- R1: After reset, control reads 0x20, the current value reads 0, the reload value reads 0, the raw and masked status read 0 and irq_o is low.
- R2: The register index is addr_i divided by 4: 0 = load, 1 = current value (read-only), 2 = control, 3 = interrupt clear (write-only), 4 = raw status, 5 = masked status, 6 = background load. Load and background load both read back the stored reload value. The interrupt clear register and undefined indices read 0. Writes to the current value register or to undefined indices change nothing.
- R3: The control fields are: bit 0 one-shot, bit 1 32-bit size, bits [3:2] prescale, bit 5 interrupt enable, bit 6 periodic and bit 7 counter enable. Bit 4 always reads 0.
- R4: A write to load stores the reload value and sets the count to it in the next cycle.
- R5: A write to background load stores the reload value and leaves the count unchanged.
- R6: The count changes only on a prescaled step while the enable bit is set. A nonzero count decrements by one.
- R7: Prescale 00 gives one step per tick, 01 one step per 16 ticks and 10 one step per 256 ticks; 11 behaves like 00. Any control write restarts the divider, so the first step comes on the 16th (or 256th) tick after the write.
- R8: In periodic mode, a step at count 0 loads the reload value, so the period is reload+1 steps.
- R9: In free-running mode, a step at count 0 loads 0xFFFF in 16-bit mode and 0xFFFFFFFF in 32-bit mode.
- R10: In one-shot mode, the count stays at 0 once it gets there. One-shot takes priority over periodic.
- R11: A step that takes the count from 1 to 0 sets the raw flag. A write of any value to interrupt clear resets it. If both happen in the same cycle, the set wins.
- R12: irq_o is the raw flag AND the interrupt-enable bit. Masked status reads 0 whenever interrupt enable is clear.
- R13: In 16-bit mode only the low 16 bits of the reload value are counted, and the current value reads back zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW (5) | Byte address of the register |
| we_i | input | 1 | Write strobe |
| wdata_i | input | DW (32) | Write data |
| rdata_o | output | DW (32) | Read data, combinational from addr_i |
| tick_i | input | 1 | Timer clock enable, one pulse per tick |
| irq_o | output | 1 | Level interrupt |

## Verification
Register reads are combinational, so the bench reads them half a cycle after it sets the address. A write or a tick is driven on the falling edge and takes effect at the next rising edge. The counter, the raw flag and irq_o therefore show its result one cycle later, and every check samples on the falling edge after that rising edge. A step needs no extra delay because the prescaler output is combinational with the tick. The bench counts the ticks it issues since the last control write and predicts each count arithmetically from the reload value, the mode and the divide ratio.

// File: rtl/interval_timer_pkg.sv
package interval_timer_pkg;
  typedef enum logic [2:0] {
    IDX_LOAD  = 3'd0,
    IDX_VALUE = 3'd1,
    IDX_CTRL  = 3'd2,
    IDX_ICLR  = 3'd3,
    IDX_RAW   = 3'd4,
    IDX_MSK   = 3'd5,
    IDX_BGLD  = 3'd6
  } reg_idx_e;

  typedef enum logic [1:0] {
    PRE_DIV1   = 2'b00,
    PRE_DIV16  = 2'b01,
    PRE_DIV256 = 2'b10,
    PRE_RSVD   = 2'b11
  } pre_sel_e;

  // bit order matches the control register layout
  typedef struct packed {
    logic     en;
    logic     periodic;
    logic     ie;
    logic     rsvd;
    pre_sel_e pre;
    logic     wide;
    logic     oneshot;
  } ctrl_t;

  localparam logic [7:0] CTRL_RST   = 8'h20;
  localparam logic [7:0] CTRL_WMASK = 8'hEF;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import interval_timer_pkg::*;
#(
  parameter int LOG_A = 4,
  parameter int LOG_B = 8
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  logic     restart_i,
  input  pre_sel_e sel_i,
  output logic     step_o
);
  localparam int PW = LOG_B;

  logic [PW-1:0] pre_q;
  logic          hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pre_q <= '0;
    else if (restart_i) pre_q <= '0;
    else if (tick_i)    pre_q <= pre_q + 1'b1;
  end

  always_comb begin
    case (sel_i)
      PRE_DIV16:  hit = &pre_q[LOG_A-1:0];
      PRE_DIV256: hit = &pre_q;
      default:    hit = 1'b1;
    endcase
  end

  assign step_o = tick_i & ~restart_i & hit;

  // R7
  div256_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && sel_i == PRE_DIV256 && !restart_i) |=> !step_o);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CW = 32,
  parameter int NW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          step_i,
  input  logic          oneshot_i,
  input  logic          periodic_i,
  input  logic          wide_i,
  input  logic [CW-1:0] reload_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic [CW-1:0] cnt_o,
  output logic          hit_o
);
  localparam logic [CW-1:0] NARROW = {{(CW-NW){1'b0}}, {NW{1'b1}}};

  logic [CW-1:0] cnt_q, mask, cur;
  logic          adv;

  assign mask  = wide_i ? '1 : NARROW;
  assign cur   = cnt_q & mask;
  assign adv   = run_i & step_i & ~load_i;
  assign hit_o = adv & (cur == CW'(1));
  assign cnt_o = cur;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i & mask;
    else if (adv) begin
      if (cur != '0)        cnt_q <= cur - 1'b1;
      else if (oneshot_i)   cnt_q <= cnt_q;
      else if (periodic_i)  cnt_q <= reload_i & mask;
      else                  cnt_q <= mask;
    end
  end

  // R6
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(run_i && step_i) && !load_i) |=> $stable(cnt_q));
  // R10
  oneshot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && oneshot_i && cur == '0) |=> $stable(cnt_q));
  // R9
  freerun_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && !oneshot_i && !periodic_i && cur == '0) |=> cnt_q == $past(mask));
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import interval_timer_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NW    = 16,
  parameter int AW    = 5,
  parameter int PRE_A = 4,
  parameter int PRE_B = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          tick_i,
  output logic          irq_o
);
  localparam int IW = AW - 2;

  ctrl_t         ctrl_q;
  logic [DW-1:0] reload_q, cnt_val;
  logic          raw_q, step, hit;
  logic [IW-1:0] idx;
  logic          wr_load, wr_ctrl, wr_iclr, wr_bgld;

  assign idx     = addr_i[AW-1:2];
  assign wr_load = we_i && idx == IW'(IDX_LOAD);
  assign wr_ctrl = we_i && idx == IW'(IDX_CTRL);
  assign wr_iclr = we_i && idx == IW'(IDX_ICLR);
  assign wr_bgld = we_i && idx == IW'(IDX_BGLD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= ctrl_t'(CTRL_RST);
      reload_q <= '0;
      raw_q    <= 1'b0;
    end else begin
      if (wr_ctrl)               ctrl_q   <= ctrl_t'(wdata_i[7:0] & CTRL_WMASK);
      if (wr_load || wr_bgld)    reload_q <= wdata_i;
      if (hit)                   raw_q    <= 1'b1;
      else if (wr_iclr)          raw_q    <= 1'b0;
    end
  end

  tmr_prescale #(.LOG_A(PRE_A), .LOG_B(PRE_B)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .restart_i (wr_ctrl),
    .sel_i     (ctrl_q.pre),
    .step_o    (step)
  );

  tmr_counter #(.CW(DW), .NW(NW)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (ctrl_q.en),
    .step_i     (step),
    .oneshot_i  (ctrl_q.oneshot),
    .periodic_i (ctrl_q.periodic),
    .wide_i     (ctrl_q.wide),
    .reload_i   (reload_q),
    .load_i     (wr_load),
    .load_val_i (wdata_i),
    .cnt_o      (cnt_val),
    .hit_o      (hit)
  );

  always_comb begin
    case (idx)
      IW'(IDX_LOAD), IW'(IDX_BGLD): rdata_o = reload_q;
      IW'(IDX_VALUE):               rdata_o = cnt_val;
      IW'(IDX_CTRL):                rdata_o = DW'(ctrl_q);
      IW'(IDX_RAW):                 rdata_o = DW'(raw_q);
      IW'(IDX_MSK):                 rdata_o = DW'(raw_q & ctrl_q.ie);
      default:                      rdata_o = '0;
    endcase
  end

  assign irq_o = raw_q & ctrl_q.ie;

  // R11
  raw_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> raw_q);
  // R11
  raw_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_iclr && !hit) |=> !raw_q);
  // R4
  load_now_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_load |=> cnt_val == ($past(ctrl_q.wide) ? $past(wdata_i)
                                               : {{(DW-NW){1'b0}}, $past(wdata_i[NW-1:0])}));
  // R5
  bgload_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_bgld && !ctrl_q.en) |=> $stable(cnt_val));
endmodule

// File: tb/interval_timer_tb.sv
module interval_timer_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tick = 1'b0;
  logic        irq;
  int          n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  interval_timer u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .tick_i(tick), .irq_o(irq)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", r, act, exp);
    end
  endtask

  task automatic wr(input int i, input logic [31:0] d);
    @(negedge clk); addr = 5'(i * 4); wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input int i, output logic [31:0] d);
    @(negedge clk); addr = 5'(i * 4); #1 d = rdata;
  endtask

  task automatic tk(input int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic chk_rd(input string r, input int i, input logic [31:0] exp);
    logic [31:0] d;
    rd(i, d);
    chk(r, d, exp);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    chk_rd("R1 ctrl", 2, 32'h20);
    chk_rd("R1 value", 1, 0);
    chk_rd("R1 load", 0, 0);
    chk_rd("R1 raw", 4, 0);
    chk_rd("R1 masked", 5, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // R8 R11 periodic sweep, divide by 1, 16-bit
    for (int l = 1; l <= 5; l++) begin
      wr(2, 32'hE0);
      wr(0, l);
      wr(3, 0);
      for (int k = 0; k <= 2 * l + 2; k++) begin
        if (k > 0) tk(1);
        chk_rd("R8 periodic value", 1, l - (k % (l + 1)));
        chk_rd("R11 raw flag", 4, (k >= l) ? 1 : 0);
      end
    end

    // R3 control readback drops bit 4
    wr(2, 32'hFF);
    chk_rd("R3 ctrl readback", 2, 32'hEF);

    // R9 free-running wraps to all-ones of the size
    wr(2, 32'hA0);
    wr(0, 2);
    tk(3);
    chk_rd("R9 wrap 16", 1, 32'hFFFF);
    tk(1);
    chk_rd("R9 after wrap 16", 1, 32'hFFFE);
    wr(2, 32'hA2);
    wr(0, 1);
    tk(2);
    chk_rd("R9 wrap 32", 1, 32'hFFFF_FFFF);

    // R13 16-bit truncation
    wr(2, 32'hA0);
    wr(0, 32'h0001_2345);
    chk_rd("R13 value narrow", 1, 32'h2345);
    chk_rd("R13 reload full", 0, 32'h0001_2345);
    // R4 immediate load, 32-bit
    wr(2, 32'h22);
    wr(0, 32'h0001_2345);
    chk_rd("R4 load wide", 1, 32'h0001_2345);

    // R10 one-shot stops at zero (priority over periodic)
    wr(2, 32'hE1);
    wr(0, 3);
    wr(3, 32'hDEAD);
    tk(6);
    chk_rd("R10 oneshot hold", 1, 0);
    chk_rd("R11 raw oneshot", 4, 1);
    chk("R12 irq on", {31'b0, irq}, 1);
    chk_rd("R12 masked on", 5, 1);
    // R12 mask off
    wr(2, 32'hC1);
    chk("R12 irq masked", {31'b0, irq}, 0);
    chk_rd("R12 masked reads 0", 5, 0);
    chk_rd("R12 raw kept", 4, 1);
    wr(3, 0);
    chk_rd("R11 clear", 4, 0);

    // R7 divide by 16 and restart on control write
    wr(2, 32'hE4);
    wr(0, 10);
    tk(15);
    chk_rd("R7 div16 before", 1, 10);
    tk(1);
    chk_rd("R7 div16 first", 1, 9);
    tk(32);
    chk_rd("R7 div16 three", 1, 7);
    tk(10);
    wr(2, 32'hE4);
    tk(15);
    chk_rd("R7 restart hold", 1, 7);
    tk(1);
    chk_rd("R7 restart step", 1, 6);
    // R7 divide by 256
    wr(2, 32'hE8);
    wr(0, 10);
    tk(255);
    chk_rd("R7 div256 before", 1, 10);
    tk(1);
    chk_rd("R7 div256 first", 1, 9);
    // R7 code 11 acts as divide by 1
    wr(2, 32'hEC);
    wr(0, 10);
    tk(3);
    chk_rd("R7 code11", 1, 7);

    // R6 disabled counter ignores ticks
    wr(2, 32'h60);
    wr(0, 4);
    tk(5);
    chk_rd("R6 disabled", 1, 4);

    // R5 background load
    wr(2, 32'hE0);
    wr(0, 3);
    wr(6, 7);
    chk_rd("R5 count kept", 1, 3);
    chk_rd("R5 reload read", 0, 7);
    chk_rd("R5 bg read", 6, 7);
    tk(3);
    chk_rd("R5 reach zero", 1, 0);
    tk(1);
    chk_rd("R5 new reload", 1, 7);

    // R2 ignored writes and undefined reads
    wr(1, 32'h55);
    chk_rd("R2 value write ignored", 1, 7);
    wr(7, 32'hFF);
    chk_rd("R2 undef write ctrl", 2, 32'hE0);
    chk_rd("R2 undef write load", 0, 7);
    chk_rd("R2 undef read", 7, 0);
    chk_rd("R2 iclr read", 3, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule